// File: doc/BRIEF.md
# Month Length Decoder

This block tells a watch's calendar logic how long the current month is. The month arrives as a two-digit BCD number from 1 to 12: a single tens bit and a four-bit units digit. Three one-hot lines come out, one for 30-day months, one for 31-day months and one for February. The block is purely combinational: a change on the month inputs reaches the outputs with no clock.

The logic is a reconvergent network of 1-to-2 demultiplexers fed from a constant 1 at the root. Each node routes a single active token to one of its two outputs under control of one month bit. Where paths meet, an OR gate merges them. The diagram is minimal, with five test nodes. The first test is the tens bit. Below tens=1 the next test is the units LSB; below tens=0 it is the units bit of weight 8. A shared sub-diagram that tests the units LSB serves both the 10–12 branch and the 8–9 branch. Codes outside 1 to 12 are don't-care as far as which line they select.

Top module: `month_days_decoder`

## Requirements
- R1: The month is `10*month_tens + month_units`, where `month_units` is one BCD digit. Valid inputs are months 1 to 12, i.e. tens=0 with units 1..9, or tens=1 with units 0..2.
- R2: For month 2 (tens=0, units=4'b0010), `days_feb` is 1 and the other two lines are 0.
- R3: For months 4, 6, 9 and 11, `days_30` is 1 and the other two lines are 0.
- R4: For months 1, 3, 5, 7, 8, 10 and 12, `days_31` is 1 and the other two lines are 0.
- R5: Inside the network, each demultiplexer passes an active token to exactly one of its outputs, and no two paths that enter the same OR merge are active at once.
- R6: The outputs follow the inputs combinationally: a new month value is reflected within the same clock period in which it is applied, with no clock edge in between.
- R7: For every one of the 32 input codes, including don't-care codes, exactly one of the three output lines is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| month_tens | input | 1 | Tens digit of the BCD month (0 or 1) |
| month_units | input | 4 | Units digit of the BCD month |
| days_30 | output | 1 | High when the month has 30 days |
| days_31 | output | 1 | High when the month has 31 days |
| days_feb | output | 1 | High when the month is February |

## Verification
Assertions inside the network check on every input change that each demultiplexer keeps its single token and that merged paths never overlap. They also check that the three outputs stay one-hot for any code, and that February and the 30-day line only appear on matching valid months. Only the bench scenarios show that every valid month selects the correct line against an independent table, and that the result settles within the same period in which the month changes.

// File: rtl/mld_pkg.sv
// Package: shared types and sizes for the month length decoder.
// Assumes BCD month input with a one-bit tens digit.
package mld_pkg;

    localparam int UNITS_W   = 4;  // width of the BCD units digit
    localparam int CLASS_CNT = 3;  // number of one-hot result lines

    // One-hot result bundle, one line per month length class
    typedef struct packed {
        logic feb;
        logic d31;
        logic d30;
    } month_len_t;

    // Decimal month value from the BCD digits (used by checks only)
    function automatic int month_value(input logic tens, input logic [UNITS_W-1:0] units);
        return (tens ? 10 : 0) + int'(units);
    endfunction

    // True for codes that name a month from 1 to 12
    function automatic logic month_valid(input logic tens, input logic [UNITS_W-1:0] units);
        if (tens) return (units <= 4'd2);
        return (units >= 4'd1) && (units <= 4'd9);
    endfunction

endpackage

// File: rtl/mld_demux_node.sv
// Module: one test node of the decision network.
// Routes the incoming token to tok_hi when sel is 1, else to tok_lo.
// Assumes at most one token travels through the network at a time.
module mld_demux_node (
    input  logic tok_in,
    input  logic sel,
    output logic tok_hi,
    output logic tok_lo
);

    // Steer the token by the tested bit
    always_comb begin
        tok_hi = tok_in & sel;
        tok_lo = tok_in & ~sel;
    end

    // Token conservation: an active input leaves by exactly one branch (R5)
    always_comb begin
        p_token_kept_r5: assert ($countones({tok_hi, tok_lo}) == (tok_in ? 1 : 0))
            else $error("demux node lost or duplicated its token");
    end

endmodule

// File: rtl/mld_or_merge.sv
// Module: convergence point of the decision network.
// ORs NUM_PATHS incoming paths; a single path becomes a plain wire.
// Assumes the incoming paths are mutually exclusive.
module mld_or_merge #(
    parameter int NUM_PATHS = 2
) (
    input  logic [NUM_PATHS-1:0] tok_in,
    output logic                 tok_out
);

    generate
        if (NUM_PATHS == 1) begin : g_wire
            // Single path: pass straight through
            assign tok_out = tok_in[0];
        end else begin : g_or
            // Several paths: reduction OR
            assign tok_out = |tok_in;
        end
    endgenerate

    // Converging paths never carry a token together (R5)
    always_comb begin
        p_paths_exclusive_r5: assert ($onehot0(tok_in))
            else $error("two converging paths active at once");
    end

endmodule

// File: rtl/month_days_decoder.sv
// Module: month length decoder built as a demultiplexer/OR network.
// Root token is constant 1. Test order: tens; then units[0] (tens=1,
// shared sub-diagram) or units[3] (tens=0). The shared sub-diagram is
// also reached from units[3]=1. Below units[3]=0 the network tests
// units[0], then units[2]. Outputs are one-hot for every input code.
module month_days_decoder (
    input  logic       month_tens,
    input  logic [3:0] month_units,
    output logic       days_30,
    output logic       days_31,
    output logic       days_feb
);
    import mld_pkg::*;

    logic tens_hi, tens_lo;      // root branches
    logic u3_hi, u3_lo;          // units weight-8 branches
    logic shr_in;                // token into shared sub-diagram
    logic shr_hi, shr_lo;        // shared sub-diagram branches
    logic odd_hi, odd_lo;        // units LSB test for months 1..7
    logic u2_hi, u2_lo;          // units weight-4 test for months 2/4/6
    month_len_t res;

    // Root node: tests the tens digit, fed by constant 1
    mld_demux_node u_n_tens (.tok_in(1'b1),   .sel(month_tens),     .tok_hi(tens_hi), .tok_lo(tens_lo));
    // tens=0: test weight-8 bit
    mld_demux_node u_n_u3   (.tok_in(tens_lo), .sel(month_units[3]), .tok_hi(u3_hi),   .tok_lo(u3_lo));
    // Merge into the shared sub-diagram (months 8..12)
    mld_or_merge #(.NUM_PATHS(2)) u_m_shr (.tok_in({tens_hi, u3_hi}), .tok_out(shr_in));
    // Shared sub-diagram: odd selects 30 days, even 31 days
    mld_demux_node u_n_shr  (.tok_in(shr_in), .sel(month_units[0]), .tok_hi(shr_hi),  .tok_lo(shr_lo));
    // Months 1..7: odd months are 31 days
    mld_demux_node u_n_odd  (.tok_in(u3_lo),  .sel(month_units[0]), .tok_hi(odd_hi),  .tok_lo(odd_lo));
    // Even months 2/4/6: weight-4 bit separates February
    mld_demux_node u_n_u2   (.tok_in(odd_lo), .sel(month_units[2]), .tok_hi(u2_hi),   .tok_lo(u2_lo));

    // Output merges
    mld_or_merge #(.NUM_PATHS(2)) u_m_d30 (.tok_in({shr_hi, u2_hi}),  .tok_out(res.d30));
    mld_or_merge #(.NUM_PATHS(2)) u_m_d31 (.tok_in({shr_lo, odd_hi}), .tok_out(res.d31));
    mld_or_merge #(.NUM_PATHS(1)) u_m_feb (.tok_in(u2_lo),            .tok_out(res.feb));

    // Drive the output pins from the result bundle
    always_comb begin
        days_30  = res.d30;
        days_31  = res.d31;
        days_feb = res.feb;
    end

    // Output lines are one-hot for every code (R7)
    always_comb begin
        p_onehot_out_r7: assert ($countones({days_30, days_31, days_feb}) == 1)
            else $error("outputs not one-hot");
    end

    // February line only for month 2 among valid codes (R2)
    always_comb begin
        if (month_valid(month_tens, month_units) && days_feb)
            p_feb_month_r2: assert (month_value(month_tens, month_units) == 2)
                else $error("February line on wrong month");
    end

    // 30-day line only for months 4, 6, 9, 11 among valid codes (R3)
    always_comb begin
        if (month_valid(month_tens, month_units) && days_30)
            p_thirty_month_r3: assert (month_value(month_tens, month_units) inside {4, 6, 9, 11})
                else $error("30-day line on wrong month");
    end

endmodule

// File: tb/month_days_decoder_tb.sv
module month_days_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       month_tens;
    logic [3:0] month_units;
    logic       days_30, days_31, days_feb;
    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done    = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    month_days_decoder u_dut (
        .month_tens(month_tens), .month_units(month_units),
        .days_30(days_30), .days_31(days_31), .days_feb(days_feb)
    );

    // Expected {d30,d31,feb} for a valid decimal month
    function automatic logic [2:0] exp_lines(input int m);
        if (m == 2) return 3'b001;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 3'b100;
        return 3'b010;
    endfunction

    function automatic string req_of(input int m);
        if (m == 2) return "R2";
        if (m == 4 || m == 6 || m == 9 || m == 11) return "R3";
        return "R4";
    endfunction

    // Apply a month (R1 encoding), check within the same period (R6)
    task automatic check_month(input int m);
        @(posedge clk);
        #1;
        month_tens  = (m >= 10);
        month_units = 4'(m % 10);
        @(negedge clk);
        n_tests++;
        if ({days_30, days_31, days_feb} !== exp_lines(m)) begin
            n_fail++;
            $display("FAIL %s/R1/R6 month %0d: got %b expected %b", req_of(m), m,
                     {days_30, days_31, days_feb}, exp_lines(m));
        end
    endtask

    // Any code, valid or not: exactly one line high (R7)
    task automatic check_onehot(input logic [4:0] code);
        @(posedge clk);
        #1;
        {month_tens, month_units} = code;
        @(negedge clk);
        n_tests++;
        if ($countones({days_30, days_31, days_feb}) != 1) begin
            n_fail++;
            $display("FAIL R7 code %b: got %b expected one hot", code,
                     {days_30, days_31, days_feb});
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy  = $urandom(32'h5EED_0042);
        month_tens  = 1'b0;
        month_units = 4'd1;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Initial applied state: January gives 31 days (R4)
        @(negedge clk);
        n_tests++;
        if ({days_30, days_31, days_feb} !== 3'b010) begin
            n_fail++;
            $display("FAIL R4 initial: got %b expected 010", {days_30, days_31, days_feb});
        end
        // Directed: all twelve months (R2, R3, R4)
        for (int m = 1; m <= 12; m++) check_month(m);
        // Corner sequences: boundary jumps 12->1, 9->10, 2->3
        check_month(12); check_month(1);
        check_month(9);  check_month(10);
        check_month(2);  check_month(3);
        // Random valid months
        for (int i = 0; i < 200; i++) check_month(int'($urandom_range(12, 1)));
        // All 32 codes, then random codes (R7)
        for (int c = 0; c < 32; c++) check_onehot(5'(c));
        for (int i = 0; i < 100; i++) check_onehot(5'($urandom_range(31, 0)));
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule